// File: doc/BRIEF.md
# Oversampled serial receiver with LIN-safe break detection

This block receives asynchronous serial characters on a single input line. The line passes through a synchroniser and is then sampled sixteen times per bit. Three samples around the middle of each bit are combined by majority vote. The block assembles 8-bit or 9-bit characters, least significant bit first, and holds each finished character in a one-deep data register until software reads it. Software drives a small register port: a control register, a status register and a data register.

A long low period on the line is reported as a break. The threshold is normally one full frame, that is the start bit, the data bits and the stop position. When the LIN mode bit is set, the threshold grows by one bit time. A slave on a fast internal oscillator can see a zero character stretched a little past ten bit times; with the longer threshold it still treats that as data and not as a break. While LIN mode is on, framing errors are never reported.

Overrun, noise, framing and parity flags each have their own enable. The enabled flags are ORed into one interrupt line. A disabled flag can still be polled. The oversampling clock is a fixed division of the system clock.

Top module: `lin_uart_rx`

## Requirements
- R1: After reset the control register (address 0), the status register (address 1), the data register (address 2) and `irq` all read 0.
- R2: A character is framed as one low start bit, the data bits LSB first, and a stop bit, each lasting 16 oversample ticks. When the stop bit is sampled, the data lands in the data register and status bit 0 (data ready) is set. Control bit 0 = 0 selects 8 data bits.
- R3: With control bit 0 = 1, nine data bits are received. The ninth bit appears in status bit 6, above the data byte. In 8-bit mode, status bit 6 reads 0.
- R4: With control bit 1 = 1, the last data bit is a parity bit. Control bit 2 selects odd (1) or even (0) parity, and a mismatch sets status bit 4. The parity bit is kept in the stored data.
- R5: If the three mid-bit samples of any bit in a frame disagree, status bit 2 (noise) is set, and the majority value is used as the bit.
- R6: If the stop bit samples low and the frame is not a break, status bit 3 (framing error) is set and the data is still stored, unless control bit 3 (LIN mode) is 1.
- R7: With LIN mode off, a line held low through the start bit, all data bits and the stop position sets status bit 5 (break). No character is stored and data ready stays 0.
- R8: With LIN mode on, the break needs one more low bit time. A zero character whose low time ends before the middle of that extra bit is stored as data 0x00, with no break and no framing error.
- R9: A character that completes while data ready is still 1 sets status bit 1 (overrun) and is discarded. The stored data is unchanged.
- R10: Reading the data register clears data ready, overrun, noise, framing and parity flags. If a character completes in the same cycle as the read, the new character is stored with data ready set and no overrun.
- R11: `irq` is high exactly when a flag is set together with its enable: overrun with control bit 4, noise with bit 5, framing with bit 6, parity with bit 7. A flag whose enable is 0 still reads as 1 in status.
- R12: Writing 1 to status bit 5 clears the break flag. After a break or a low stop bit, no new start bit is accepted until the line has been seen high, so a line that stays low raises the break only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idles high |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_rd | input | 1 | Read strobe; a read of address 2 clears the flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register, combinational |
| irq | output | 1 | Interrupt request from enabled flags |

## Verification
Two things can land on the same clock edge: a character finishing its stop bit, and the software read of the data register that clears the flags. The bench leaves one character unread and then sends a second one. It fires a single-cycle read at each clock offset in a window around the second character's stop-bit decision, so exactly one trial hits the finishing edge. After each trial only two states are legal: the new character stored with data ready set and no overrun, or every flag cleared with the old byte still held. Once a trial gives the late outcome, no later offset may give the early one.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;

    localparam int unsigned REG_AW = 2;
    localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_DATA = 2'd2;
    localparam int unsigned STAT_BRK = 5;

    // Control register, bit 7 down to bit 0
    typedef struct packed {
        logic ie_pf;
        logic ie_fe;
        logic ie_nf;
        logic ie_or;
        logic lin_brk;
        logic par_odd;
        logic par_en;
        logic nine_bit;
    } rx_ctrl_t;

    // One finished character handed from the framer to the register file
    typedef struct packed {
        logic [7:0] data;
        logic       bit9;
        logic       noise;
        logic       frm_err;
        logic       par_err;
    } rx_char_t;

endpackage

// File: rtl/lin_rx_tick.sv
module lin_rx_tick #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = 1'b0;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) begin
            cnt_d  = '0;
            tick_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (DIV > 1) begin : g_gap
            // R2
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/lin_rx_sampler.sv
module lin_rx_sampler #(
    parameter int unsigned SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    input  logic tick_i,
    output logic line_o,
    output logic vote_o,
    output logic noisy_o
);
    typedef struct packed {
        logic [SYNC-1:0] sync;
        logic [1:0]      hist;
    } samp_t;

    samp_t d, q;

    always_comb begin
        d      = q;
        line_o = q.sync[SYNC-1];
        d.sync = {q.sync[SYNC-2:0], rxd_i};
        if (tick_i) d.hist = {q.hist[0], line_o};
        // the two history samples plus the present one form the mid-bit vote
        vote_o  = (q.hist[1] & q.hist[0]) | (q.hist[1] & line_o) | (q.hist[0] & line_o);
        noisy_o = !((q.hist[1] == q.hist[0]) && (q.hist[0] == line_o));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

endmodule

// File: rtl/lin_rx_frame.sv
module lin_rx_frame import lin_rx_pkg::*; #(
    parameter int unsigned OVS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick_i,
    input  logic     line_i,
    input  logic     vote_i,
    input  logic     noisy_i,
    input  logic     nine_i,
    input  logic     par_en_i,
    input  logic     par_odd_i,
    input  logic     lin_i,
    output logic     done_o,
    output logic     brk_o,
    output rx_char_t char_o
);
    localparam int unsigned PW = $clog2(OVS);
    localparam logic [PW-1:0] MID  = PW'(OVS / 2 + 1);
    localparam logic [PW-1:0] LAST = PW'(OVS - 1);

    typedef enum logic { S_IDLE, S_RECV } fstate_e;

    typedef struct packed {
        fstate_e       st;
        logic          armed;
        logic [PW-1:0] phase;
        logic [3:0]    idx;
        logic [8:0]    shreg;
        logic          noise;
        logic          all_low;
    } frame_t;

    frame_t d, q;
    logic [3:0] dbits;
    logic [8:0] word;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        brk_o  = 1'b0;
        dbits  = nine_i ? 4'd9 : 4'd8;
        word   = nine_i ? q.shreg : {1'b0, q.shreg[8:1]};
        char_o.data    = word[7:0];
        char_o.bit9    = word[8];
        char_o.noise   = q.noise | noisy_i;
        char_o.par_err = par_en_i & ((^word) ^ par_odd_i);
        char_o.frm_err = 1'b0;

        if (tick_i) begin
            unique case (q.st)
                S_IDLE: begin
                    if (!q.armed) begin
                        d.armed = line_i;
                    end else if (!line_i) begin
                        d.st      = S_RECV;
                        d.phase   = PW'(1);
                        d.idx     = '0;
                        d.noise   = 1'b0;
                        d.all_low = 1'b1;
                    end
                end
                S_RECV: begin
                    d.phase = (q.phase == LAST) ? '0 : q.phase + 1'b1;
                    if (q.phase == LAST) d.idx = q.idx + 1'b1;
                    if (q.phase == MID) begin
                        d.noise   = q.noise | noisy_i;
                        d.all_low = q.all_low & ~vote_i;
                        if (q.idx == 4'd0) begin
                            if (vote_i) d.st = S_IDLE;            // false start
                        end else if (q.idx <= dbits) begin
                            d.shreg = {vote_i, q.shreg[8:1]};
                        end else if (q.idx == dbits + 4'd1) begin
                            if (vote_i) begin
                                done_o = 1'b1;
                            end else if (!d.all_low) begin
                                done_o         = 1'b1;
                                char_o.frm_err = !lin_i;
                            end else if (!lin_i) begin
                                brk_o = 1'b1;
                            end
                            // all low in LIN mode: decide on the extra bit
                        end else begin
                            if (vote_i) done_o = 1'b1;
                            else        brk_o  = 1'b1;
                        end
                        if (done_o || brk_o) begin
                            d.st    = S_IDLE;
                            d.armed = vote_i;
                        end
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RECV) |-> (q.idx <= 4'd11));

endmodule

// File: rtl/lin_rx_regs.sv
module lin_rx_regs import lin_rx_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic              done_i,
    input  logic              brk_i,
    input  rx_char_t          char_i,
    output rx_ctrl_t          ctrl_o,
    output logic              irq_o
);
    typedef struct packed {
        rx_ctrl_t   ctrl;
        logic       rdrf;
        logic       ovr;
        logic       nf;
        logic       fe;
        logic       pf;
        logic       brk;
        logic       bit9;
        logic [7:0] data;
    } regs_t;

    regs_t d, q;
    logic  rd_clr;

    always_comb begin
        d      = q;
        rd_clr = rd_i && (addr_i == ADDR_DATA);
        if (rd_clr) begin
            d.rdrf = 1'b0;
            d.ovr  = 1'b0;
            d.nf   = 1'b0;
            d.fe   = 1'b0;
            d.pf   = 1'b0;
        end
        if (wr_i && (addr_i == ADDR_CTRL)) d.ctrl = rx_ctrl_t'(wdata_i);
        if (wr_i && (addr_i == ADDR_STAT) && wdata_i[STAT_BRK]) d.brk = 1'b0;
        if (brk_i) d.brk = 1'b1;
        if (done_i) begin
            if (q.rdrf && !rd_clr) begin
                d.ovr = 1'b1;
            end else begin
                d.rdrf = 1'b1;
                d.data = char_i.data;
                d.bit9 = char_i.bit9;
                d.nf   = char_i.noise;
                d.fe   = char_i.frm_err;
                d.pf   = char_i.par_err;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr_i)
            ADDR_CTRL: rdata_o = q.ctrl;
            ADDR_STAT: rdata_o = {1'b0, q.bit9, q.brk, q.pf, q.fe, q.nf, q.ovr, q.rdrf};
            ADDR_DATA: rdata_o = q.data;
            default:   rdata_o = '0;
        endcase
    end

    assign ctrl_o = q.ctrl;
    assign irq_o  = (q.ovr & q.ctrl.ie_or) | (q.nf & q.ctrl.ie_nf)
                  | (q.fe & q.ctrl.ie_fe) | (q.pf & q.ctrl.ie_pf);

    // R9
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> $past(q.rdrf));

    // R8
    lin_no_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q.ctrl.lin_brk) |-> !$rose(q.fe));

    // R10
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !done_i) |=> !q.rdrf);

    // R7
    brk_no_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.brk) |-> !$rose(q.rdrf));

endmodule

// File: rtl/lin_uart_rx.sv
module lin_uart_rx import lin_rx_pkg::*; #(
    parameter int unsigned TICK_DIV    = 4,
    parameter int unsigned OVS         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    logic     tick, line, vote, noisy, done, brk;
    rx_char_t rx_char;
    rx_ctrl_t ctrl;

    lin_rx_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    lin_rx_sampler #(.SYNC(SYNC_STAGES)) u_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd_i   (rxd),
        .tick_i  (tick),
        .line_o  (line),
        .vote_o  (vote),
        .noisy_o (noisy)
    );

    lin_rx_frame #(.OVS(OVS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .line_i    (line),
        .vote_i    (vote),
        .noisy_i   (noisy),
        .nine_i    (ctrl.nine_bit),
        .par_en_i  (ctrl.par_en),
        .par_odd_i (ctrl.par_odd),
        .lin_i     (ctrl.lin_brk),
        .done_o    (done),
        .brk_o     (brk),
        .char_o    (rx_char)
    );

    lin_rx_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .done_i  (done),
        .brk_i   (brk),
        .char_i  (rx_char),
        .ctrl_o  (ctrl),
        .irq_o   (irq)
    );

endmodule

// File: tb/lin_uart_rx_tb.sv
module lin_uart_rx_tb;
    localparam int DIV = 4;
    localparam int OVS = 16;
    localparam int BIT = DIV * OVS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lin_uart_rx #(.TICK_DIV(DIV), .OVS(OVS), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [7:0] st(bit rdrf, bit ovr, bit nf, bit fe, bit pf, bit brk, bit b9);
        return {1'b0, b9, brk, pf, fe, nf, ovr, rdrf};
    endfunction

    function automatic bit par_bad(logic [8:0] w, bit odd);
        return (^w) ^ odd;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // start bit, nb data bits LSB first, stop level, one idle bit; optional glitch
    task automatic send_word(input logic [8:0] w, input int nb, input logic stop, input int glitch);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = w[i];
            if (i == glitch) begin
                repeat (BIT / 2) @(negedge clk);
                rxd = ~w[i];
                repeat (DIV) @(negedge clk);
                rxd = w[i];
                repeat (BIT / 2 - DIV) @(negedge clk);
            end else begin
                repeat (BIT) @(negedge clk);
            end
        end
        rxd = stop;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic hold_low(input int nclk);
        rxd = 1'b0;
        repeat (nclk) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] s;
        int seen_late;
        int seen_early;
        void'($urandom(32'h1A2B3C4D));
        seen_late  = 0;
        seen_early = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2 * BIT) @(negedge clk);

        // R1 reset state
        reg_read(2'd0, v); chk("R1 ctrl", v, 8'h00);
        reg_read(2'd1, v); chk("R1 status", v, 8'h00);
        reg_read(2'd2, v); chk("R1 data", v, 8'h00);
        chk("R1 irq", irq, 1'b0);

        // R2 plain 8-bit character
        send_word(9'h0A5, 8, 1'b1, -1);
        reg_read(2'd1, v); chk("R2 status", v, st(1,0,0,0,0,0,0));
        reg_read(2'd2, v); chk("R2 data", v, 8'hA5);
        reg_read(2'd1, v); chk("R10 status after read", v, 8'h00);

        // R3 nine-bit character
        reg_write(2'd0, 8'h01);
        send_word(9'h1C3, 9, 1'b1, -1);
        reg_read(2'd1, v); chk("R3 status ninth bit", v, st(1,0,0,0,0,0,1));
        reg_read(2'd2, v); chk("R3 data", v, 8'hC3);

        // R4 even parity with a wrong parity bit (0x03 has even ones, bit7 set)
        reg_write(2'd0, 8'h02);
        send_word(9'h083, 8, 1'b1, -1);
        reg_read(2'd1, v); chk("R4 parity error", v, st(1,0,0,0,1,0,0));
        reg_read(2'd2, v); chk("R4 parity kept in data", v, 8'h83);

        // R2/R3/R4 constrained random frames
        for (int n = 0; n < 30; n++) begin
            logic nine, pe, po, lin;
            logic [8:0] w;
            logic exp_pf;
            nine = 1'($urandom % 2);
            pe   = 1'($urandom % 2);
            po   = 1'($urandom % 2);
            lin  = 1'($urandom % 2);
            w    = 9'($urandom);
            if (!nine) w[8] = 1'b0;
            if (n == 0) w = 9'h000;
            reg_write(2'd0, {4'b0000, lin, po, pe, nine});
            send_word(w, nine ? 9 : 8, 1'b1, -1);
            exp_pf = pe & par_bad(w, po);
            reg_read(2'd1, v); chk("R3 R4 random status", v, st(1,0,0,0,exp_pf,0,nine & w[8]));
            reg_read(2'd2, v); chk("R2 random data", v, w[7:0]);
        end

        // R5 noise glitch on one sample of data bit 3
        reg_write(2'd0, 8'h00);
        send_word(9'h0F0, 8, 1'b1, 3);
        reg_read(2'd1, v); chk("R5 noise flag", v, st(1,0,1,0,0,0,0));
        reg_read(2'd2, v); chk("R5 majority data", v, 8'hF0);

        // R6 stop bit low, LIN off, framing error interrupt enabled
        reg_write(2'd0, 8'h40);
        send_word(9'h055, 8, 1'b0, -1);
        reg_read(2'd1, v); chk("R6 framing error", v, st(1,0,0,1,0,0,0));
        chk("R11 irq on framing error", irq, 1'b1);
        reg_write(2'd0, 8'h00);
        chk("R11 irq masked, flag kept", irq, 1'b0);
        reg_read(2'd1, v); chk("R11 flag still polled", v, st(1,0,0,1,0,0,0));
        reg_read(2'd2, v); chk("R6 data kept", v, 8'h55);

        // R7 normal break of ten low bit times
        hold_low(10 * BIT);
        reg_read(2'd1, v); chk("R7 break flag no data", v, st(0,0,0,0,0,1,0));
        reg_write(2'd1, 8'h20);
        reg_read(2'd1, v); chk("R12 break cleared", v, 8'h00);

        // R8 LIN mode: zero char stretched to 10.25 bit times is data
        reg_write(2'd0, 8'h08);
        hold_low(10 * BIT + BIT / 4);
        reg_read(2'd1, v); chk("R8 stretched zero is data", v, st(1,0,0,0,0,0,0));
        reg_read(2'd2, v); chk("R8 stretched zero value", v, 8'h00);
        hold_low(12 * BIT);
        reg_read(2'd1, v); chk("R8 long low is break", v, st(0,0,0,0,0,1,0));
        reg_write(2'd1, 8'h20);
        send_word(9'h055, 8, 1'b0, -1);
        reg_read(2'd1, v); chk("R8 framing error suppressed", v, st(1,0,0,0,0,0,0));
        reg_read(2'd2, v); chk("R8 data", v, 8'h55);

        // R12 line stuck low: one break only, no rearm until high
        reg_write(2'd0, 8'h00);
        rxd = 1'b0;
        repeat (12 * BIT) @(negedge clk);
        reg_write(2'd1, 8'h20);
        repeat (12 * BIT) @(negedge clk);
        reg_read(2'd1, v); chk("R12 no second break while low", v, 8'h00);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        send_word(9'h05A, 8, 1'b1, -1);
        reg_read(2'd2, v); chk("R12 rearmed after high", v, 8'h5A);

        // R9 overrun with its interrupt enabled
        reg_write(2'd0, 8'h10);
        send_word(9'h011, 8, 1'b1, -1);
        send_word(9'h022, 8, 1'b1, -1);
        reg_read(2'd1, v); chk("R9 overrun", v, st(1,1,0,0,0,0,0));
        chk("R11 irq on overrun", irq, 1'b1);
        reg_read(2'd2, v); chk("R9 old data kept", v, 8'h11);
        chk("R10 irq after clearing read", irq, 1'b0);
        reg_write(2'd0, 8'h00);

        // R10 read against character completion, swept across the edge
        for (int x = 606; x <= 625; x++) begin
            logic [7:0] a, b, dat;
            a = 8'h3C;
            b = 8'h81 ^ 8'(x);
            reg_read(2'd2, dat);
            send_word({1'b0, a}, 8, 1'b1, -1);
            fork
                send_word({1'b0, b}, 8, 1'b1, -1);
                begin
                    repeat (x) @(negedge clk);
                    bus_addr = 2'd2;
                    bus_rd   = 1'b1;
                    @(negedge clk);
                    bus_rd = 1'b0;
                end
            join
            reg_read(2'd1, s);
            reg_read(2'd2, dat);
            if (s == 8'h01 && dat == b) begin
                if (seen_late != 0) chk("R10 early after late", 32'd1, 32'd0);
                seen_early++;
            end else if (s == 8'h00 && dat == a) begin
                seen_late++;
            end else begin
                chk("R10 collision state", {16'd0, s, dat}, {16'd0, 8'h01, b});
            end
        end
        chk("R10 early outcome seen", seen_early > 0, 1'b1);
        chk("R10 late outcome seen", seen_late > 0, 1'b1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1-path run actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule